// File: doc/BRIEF.md
# Pipelined Inner-Product Accumulator

This block computes the inner product of two integer operand streams. It accepts one pair of 16-bit signed operands per clock and returns the sum of their products as a 40-bit signed value. A four-stage registered multiplier feeds a four-stage registered adder. The output of the adder loops back to its own second operand. Four independent partial sums therefore travel around the adder ring together, one per pipeline slot, so a product never waits for an earlier sum to finish.

The operands arrive with a valid flag and a last flag, and the block returns ready to pace them. Once the last pair is accepted, the block refuses further input. It lets the multiplier drain and then merges the four partial sums through the same adder in a fixed three-step schedule. It presents the total on the result port together with a one-cycle done pulse. A stream may hold any number of pairs from one upward, with idle cycles anywhere inside it. A ring slot that never received a product counts as zero.

Top module: `dotp_accum`

## Requirements
- R1: While reset is held, and after it is released, `in_ready` is high and `res_valid` is low.
- R2: For a stream of pairs accepted with `in_valid && in_ready`, the value on `res_data` during the done pulse equals the sum of the signed products. The sum is taken in 40-bit two's complement and starts from zero. Outside the done pulse, `res_data` does not change.
- R3: The result is correct for a stream of one pair and for lengths that are not a multiple of four.
- R4: Idle cycles (`in_valid` low) between pairs of a stream do not change the result.
- R5: `in_ready` goes low in the cycle after the pair carrying `in_last` is accepted. It stays low until the done pulse, and pairs offered while it is low have no effect on the result.
- R6: `res_valid` is high for exactly one cycle, 16 clock cycles after the edge that accepted the last pair.
- R7: `in_ready` is high again in the cycle in which `res_valid` is high. Each new stream then accumulates from zero, independent of the previous one.
- R8: Operands at the extremes of the 16-bit signed range (-32768 and 32767), summed over a dozen pairs, give the exact result without overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can accept a pair this cycle |
| in_last | input | 1 | Marks the final pair of the stream |
| in_a | input | 16 | First operand, signed |
| in_b | input | 16 | Second operand, signed |
| res_valid | output | 1 | One-cycle done pulse |
| res_data | output | 40 | Inner product, signed |

## Verification
A ring slot whose feedback is not gated to zero, or that holds a stale sum from the previous stream, shows up directly as a wrong `res_data` value. It appears in the first done pulse after the fault, and the back-to-back streams make the stale case visible. A merge schedule that is off by one cycle either drops a partial sum or adds an empty slot. In both cases the result value is wrong, or the done pulse moves away from cycle 16, so the error is visible at the first stream. A control phase that misses a transition leaves `in_ready` low, and the wait for the done pulse reports it within a few dozen cycles.

// File: rtl/dotp_pkg.sv
package dotp_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_FLUSH = 2'd1,
    PH_MERGE = 2'd2
  } phase_e;
endpackage

// File: rtl/dotp_mul_pipe.sv
module dotp_mul_pipe #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 40,
  parameter int unsigned DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_v,
  input  logic                    in_last,
  input  logic signed [IN_W-1:0]  in_a,
  input  logic signed [IN_W-1:0]  in_b,
  output logic                    out_v,
  output logic                    out_last,
  output logic signed [ACC_W-1:0] out_p
);
  localparam int unsigned PROD_W = 2 * IN_W;

  logic signed [PROD_W-1:0] prod_w;
  logic signed [ACC_W-1:0]  prod_ext;
  logic [DEPTH-1:0]         v_q;
  logic [DEPTH-1:0]         l_q;
  logic signed [ACC_W-1:0]  p_q [DEPTH];

  assign prod_w   = in_a * in_b;
  assign prod_ext = {{(ACC_W-PROD_W){prod_w[PROD_W-1]}}, prod_w};

  // control bits carry reset, data stages only load when their input is valid
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      l_q <= '0;
    end else begin
      v_q <= {v_q[DEPTH-2:0], in_v};
      l_q <= {l_q[DEPTH-2:0], in_v & in_last};
    end
  end

  always_ff @(posedge clk) begin
    if (in_v) p_q[0] <= prod_ext;
    for (int s = 1; s < DEPTH; s++) begin
      if (v_q[s-1]) p_q[s] <= p_q[s-1];
    end
  end

  assign out_v    = v_q[DEPTH-1];
  assign out_last = l_q[DEPTH-1];
  assign out_p    = p_q[DEPTH-1];
endmodule

// File: rtl/dotp_add_pipe.sv
module dotp_add_pipe #(
  parameter int unsigned ACC_W = 40,
  parameter int unsigned DEPTH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_v,
  input  logic signed [ACC_W-1:0] op_x,
  input  logic signed [ACC_W-1:0] op_y,
  output logic                    out_v,
  output logic signed [ACC_W-1:0] out_s
);
  logic [DEPTH-1:0]        v_q;
  logic signed [ACC_W-1:0] s_q [DEPTH];
  logic signed [ACC_W-1:0] sum_w;

  assign sum_w = op_x + op_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= {v_q[DEPTH-2:0], in_v};
  end

  always_ff @(posedge clk) begin
    if (in_v) s_q[0] <= sum_w;
    for (int s = 1; s < DEPTH; s++) begin
      if (v_q[s-1]) s_q[s] <= s_q[s-1];
    end
  end

  assign out_v = v_q[DEPTH-1];
  assign out_s = s_q[DEPTH-1];
endmodule

// File: rtl/dotp_ctrl.sv
module dotp_ctrl
  import dotp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic mul_last,
  output logic in_ready,
  output logic recirc_en,
  output logic hold_ld,
  output logic comb_en,
  output logic res_ld,
  output logic merge_on
);
  localparam int unsigned STEP_W = 4;
  // merge schedule, counted from the cycle after the last product enters the ring
  localparam logic [STEP_W-1:0] ST_HOLD_A = 4'd1;
  localparam logic [STEP_W-1:0] ST_ADD_A  = 4'd2;
  localparam logic [STEP_W-1:0] ST_HOLD_B = 4'd3;
  localparam logic [STEP_W-1:0] ST_ADD_B  = 4'd4;
  localparam logic [STEP_W-1:0] ST_HOLD_C = 4'd6;
  localparam logic [STEP_W-1:0] ST_ADD_C  = 4'd8;
  localparam logic [STEP_W-1:0] ST_DONE   = 4'd12;

  phase_e            ph_q, ph_d;
  logic [STEP_W-1:0] step_q, step_d;

  always_comb begin
    ph_d   = ph_q;
    step_d = step_q;
    unique case (ph_q)
      PH_RUN: begin
        if (in_valid && in_last) ph_d = PH_FLUSH;
      end
      PH_FLUSH: begin
        if (mul_last) begin
          ph_d   = PH_MERGE;
          step_d = 4'd1;
        end
      end
      PH_MERGE: begin
        step_d = step_q + 4'd1;
        if (step_q == ST_DONE) begin
          ph_d   = PH_RUN;
          step_d = '0;
        end
      end
      default: begin
        ph_d   = PH_RUN;
        step_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_RUN;
      step_q <= '0;
    end else begin
      ph_q   <= ph_d;
      step_q <= step_d;
    end
  end

  assign merge_on  = (ph_q == PH_MERGE);
  assign in_ready  = (ph_q == PH_RUN);
  assign recirc_en = !merge_on;
  assign hold_ld   = merge_on && ((step_q == ST_HOLD_A) || (step_q == ST_HOLD_B) ||
                                  (step_q == ST_HOLD_C));
  assign comb_en   = merge_on && ((step_q == ST_ADD_A) || (step_q == ST_ADD_B) ||
                                  (step_q == ST_ADD_C));
  assign res_ld    = merge_on && (step_q == ST_DONE);
endmodule

// File: rtl/dotp_accum.sv
module dotp_accum
  import dotp_pkg::*;
#(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned ACC_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_last,
  input  logic [IN_W-1:0]  in_a,
  input  logic [IN_W-1:0]  in_b,
  output logic             res_valid,
  output logic [ACC_W-1:0] res_data
);
  localparam int unsigned STAGES = LANES;

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic                    accept;
  logic                    mul_v, mul_last;
  logic signed [ACC_W-1:0] mul_p;
  logic                    fb_v;
  logic signed [ACC_W-1:0] fb_s;
  logic                    recirc_en, hold_ld, comb_en, res_ld, merge_on;
  logic                    add_v;
  logic signed [ACC_W-1:0] add_x, add_y;
  logic signed [ACC_W-1:0] fb_gated;
  logic signed [ACC_W-1:0] hold_q, hold_d;
  logic [ACC_W-1:0]        res_q, res_d;
  logic                    res_v_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign accept = in_valid && in_ready;

  dotp_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .mul_last  (mul_last),
    .in_ready  (in_ready),
    .recirc_en (recirc_en),
    .hold_ld   (hold_ld),
    .comb_en   (comb_en),
    .res_ld    (res_ld),
    .merge_on  (merge_on)
  );

  dotp_mul_pipe #(.IN_W(IN_W), .ACC_W(ACC_W), .DEPTH(STAGES)) u_mul (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .in_v     (accept),
    .in_last  (in_last),
    .in_a     ($signed(in_a)),
    .in_b     ($signed(in_b)),
    .out_v    (mul_v),
    .out_last (mul_last),
    .out_p    (mul_p)
  );

  // an empty ring slot contributes zero
  assign fb_gated = fb_v ? fb_s : '0;

  always_comb begin
    add_v = 1'b0;
    add_x = '0;
    add_y = '0;
    if (recirc_en) begin
      add_v = mul_v || fb_v;
      add_x = mul_v ? mul_p : '0;
      add_y = fb_gated;
    end else if (comb_en) begin
      add_v = 1'b1;
      add_x = fb_gated;
      add_y = hold_q;
    end
  end

  dotp_add_pipe #(.ACC_W(ACC_W), .DEPTH(STAGES)) u_add (
    .clk   (clk),
    .rst_n (rst_int_n),
    .in_v  (add_v),
    .op_x  (add_x),
    .op_y  (add_y),
    .out_v (fb_v),
    .out_s (fb_s)
  );

  always_comb begin
    hold_d = hold_q;
    res_d  = res_q;
    if (hold_ld) hold_d = fb_gated;
    if (res_ld)  res_d  = fb_gated;
  end

  always_ff @(posedge clk) begin
    if (hold_ld) hold_q <= hold_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      res_q   <= '0;
      res_v_q <= 1'b0;
    end else begin
      if (res_ld) res_q <= res_d;
      res_v_q <= res_ld;
    end
  end

  assign res_valid = res_v_q;
  assign res_data  = res_q;
endmodule

// File: rtl/dotp_accum_chk.sv
module dotp_accum_chk #(
  parameter int unsigned ACC_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             res_valid,
  input logic [ACC_W-1:0] res_data,
  input logic             merge_on,
  input logic             mul_v
);
  assert_busy_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  assert_merge_no_product_R5: assert property (@(posedge clk) disable iff (!rst_n)
    merge_on |-> !mul_v);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_ready_back_only_at_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> res_valid);

  assert_ready_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> in_ready);

  assert_result_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> $stable(res_data));
endmodule

bind dotp_accum dotp_accum_chk #(.ACC_W(ACC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_last   (in_last),
  .res_valid (res_valid),
  .res_data  (res_data),
  .merge_on  (merge_on),
  .mul_v     (mul_v)
);

// File: tb/dotp_accum_tb_top.sv
`timescale 1ns/1ps
module dotp_accum_tb_top;
  localparam int IN_W  = 16;
  localparam int ACC_W = 40;
  localparam int LAT   = 16;

  logic             clk;
  logic             rst_n;
  logic             in_valid;
  logic             in_ready;
  logic             in_last;
  logic [IN_W-1:0]  in_a;
  logic [IN_W-1:0]  in_b;
  logic             res_valid;
  logic [ACC_W-1:0] res_data;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  dotp_accum dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .in_a      (in_a),
    .in_b      (in_b),
    .res_valid (res_valid),
    .res_data  (res_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [IN_W-1:0] pick(input int i, input int style, input bit second);
    int v;
    if (style == 2) begin
      if (second) v = -32768;
      else        v = (i % 2 == 0) ? -32768 : 32767;
    end else if (second) begin
      v = ((i * 53 + style * 17 + 3) % 199) - 99;
    end else begin
      v = ((i * 29 + style * 11 + 7) % 251) - 125;
    end
    return v[IN_W-1:0];
  endfunction

  // style 0: back-to-back pairs, 1: idle cycles inserted, 2: extreme operands
  task automatic run_job(input int n, input int style, input string req);
    logic [IN_W-1:0]  a, b;
    logic [ACC_W-1:0] expv;
    longint           prod;
    int               lat;
    expv = '0;
    for (int i = 0; i < n; i++) begin
      a = pick(i, style, 1'b0);
      b = pick(i, style, 1'b1);
      prod = longint'($signed(a)) * longint'($signed(b));
      expv = expv + prod[ACC_W-1:0];
      if (style == 1 && (i % 3) == 1) begin
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
      end
      @(negedge clk);
      if (i == 0) check(in_ready === 1'b1, "R7", "ready at stream start", in_ready, 1);
      in_valid = 1'b1;
      in_a     = a;
      in_b     = b;
      in_last  = (i == n - 1);
    end
    @(negedge clk);
    check(in_ready === 1'b0, "R5", "ready after last pair", in_ready, 0);
    lat = 0;
    while (res_valid !== 1'b1 && lat < 64) begin
      // pairs offered while busy must be ignored (R5)
      in_valid = 1'b1;
      in_a     = 16'h7fff;
      in_b     = 16'h7fff;
      in_last  = lat[0];
      @(negedge clk);
      lat++;
      if (res_valid !== 1'b1 && in_ready !== 1'b0)
        check(1'b0, "R5", "ready while busy", in_ready, 0);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    check(lat == LAT, "R6", "done latency", lat, LAT);
    check(res_data === expv, req, "inner product",
          longint'($signed(res_data)), longint'($signed(expv)));
    check(in_ready === 1'b1, "R7", "ready during done", in_ready, 1);
    @(negedge clk);
    check(res_valid === 1'b0, "R6", "done pulse width", res_valid, 0);
    check(res_data === expv, "R2", "result held after done",
          longint'($signed(res_data)), longint'($signed(expv)));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_a     = '0;
    in_b     = '0;
    repeat (3) @(negedge clk);
    check(in_ready === 1'b1, "R1", "ready in reset", in_ready, 1);
    check(res_valid === 1'b0, "R1", "done in reset", res_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(in_ready === 1'b1, "R1", "ready after reset", in_ready, 1);
    check(res_valid === 1'b0, "R1", "done after reset", res_valid, 0);

    run_job(8, 0, "R2");   // two full sections per lane
    run_job(1, 0, "R3");   // single pair, three empty lanes
    run_job(7, 0, "R3");   // length not a multiple of four
    run_job(10, 1, "R4");  // idle cycles inside the stream
    run_job(12, 2, "R8");  // extreme operands
    run_job(5, 0, "R7");   // follows directly, must start from zero
    run_job(5, 0, "R7");   // same stream again gives the same value

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule